// File: doc/BRIEF.md
# Receive FIFO Error-Count Tracker

This block is the character queue that sits behind a serial receiver. Every byte the receiver hands over arrives with two flags: one marking a parity fault and one marking a framing fault. The byte and its flags are stored together in a first-in first-out queue of 64 entries. The host drains the queue through a pop port.

Alongside the queue the block keeps two live tallies. One counts the resident bytes that carry a parity fault. The other counts the resident bytes that carry a framing fault. A tally rises when a flagged byte is accepted and falls when a flagged byte leaves the queue. Both tallies are packed into one 16-bit read-only status word.

The receiver's error-summary flag passes through as a qualifier that tells software when the tallies should be read. Both the push port and the pop port are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. `in_ready` falls only when all 64 entries are occupied. `out_valid` is high whenever at least one entry is stored, and `out_data`, `out_par_err` and `out_frm_err` then show the oldest entry. Holding `out_ready` high while `out_valid` is low has no effect.

Top module: `rxq_err_tracker`

## Requirements
- R1: After a synchronous active-low reset, `status_word` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: On an accepted push whose parity flag is 1, the parity tally (`status_word[13:8]`) rises by one. On an accepted pop of a stored byte whose parity flag is 1, it falls by one.
- R3: The framing tally (`status_word[5:0]`) follows the same rules using the framing flag, independently of the parity tally.
- R4: When a push and a pop are accepted in the same cycle, each tally takes the net change in that cycle. The change is +1, -1 or 0 depending on the flags of the incoming byte and of the departing byte.
- R5: In `status_word`, bits 15, 14, 7 and 6 always read 0. Bits 13 to 8 hold the parity tally and bits 5 to 0 hold the framing tally.
- R6: Each tally is 6 bits wide and wraps, so when all 64 stored bytes carry the same fault, that tally reads 0.
- R7: `in_ready` is 0 exactly when 64 bytes are stored. A push offered while `in_ready` is 0 is dropped and leaves the queue contents and both tallies unchanged.
- R8: A pop request while the queue is empty (`out_valid` 0) is ignored and leaves both tallies unchanged.
- R9: Asserting `fifo_clr` empties the queue and clears both tallies to 0 on the next edge. It takes priority over a push or pop in the same cycle.
- R10: Bytes leave in arrival order, and each byte leaves with the parity and framing flags it was stored with.
- R11: `counts_valid` follows `err_summary` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_clr | input | 1 | Synchronous queue flush, clears both tallies |
| in_valid | input | 1 | Push request from the receiver |
| in_ready | output | 1 | Queue can accept a byte (not full) |
| in_data | input | 8 | Received byte |
| in_par_err | input | 1 | Parity fault flag for `in_data` |
| in_frm_err | input | 1 | Framing fault flag for `in_data` |
| out_valid | output | 1 | Queue holds at least one byte |
| out_ready | input | 1 | Host takes the head byte |
| out_data | output | 8 | Oldest stored byte |
| out_par_err | output | 1 | Parity flag of the oldest byte |
| out_frm_err | output | 1 | Framing flag of the oldest byte |
| err_summary | input | 1 | Receiver error-summary flag |
| counts_valid | output | 1 | Tallies are to be trusted (follows `err_summary`) |
| status_word | output | 16 | {2'b0, parity tally, 2'b0, framing tally} |

## Verification
The tallies are driven in several ways: pushes with only the parity flag, only the framing flag, both flags, or neither, and pops of heads carrying each flag combination. Running these patterns shows that the two tallies move independently and that a clean byte moves neither. Simultaneous push and pop cycles are chosen so that the net change is +1, -1 and 0. These cases separate a correct net update from designs that apply only the push or only the pop. The queue is then filled to 64 parity-flagged bytes to show the wrap to 0 and the dropped push when full. Popping on an empty queue and flushing while a push is offered show that those requests leave the tallies untouched.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NTAG   = 2;   // tag index 0: parity, 1: framing
  localparam int unsigned TAG_PAR = 0;
  localparam int unsigned TAG_FRM = 1;

  typedef struct packed {
    logic [NTAG-1:0]   tags;
    logic [BYTE_W-1:0] data;
  } rxq_entry_t;

  localparam int unsigned ENTRY_W = $bits(rxq_entry_t);
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned OW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [OW-1:0] FULL_LVL = OW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [OW-1:0] level;

  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rxq_tag_count.sv
module rxq_tag_count #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_err_tracker.sv
module rxq_err_tracker #(
  parameter int unsigned DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_clr,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_par_err,
  input  logic        in_frm_err,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_par_err,
  output logic        out_frm_err,
  input  logic        err_summary,
  output logic        counts_valid,
  output logic [15:0] status_word
);
  import rxq_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH);   // tally width, wraps at DEPTH
  localparam int unsigned PAR_LSB = 8;
  localparam int unsigned FRM_LSB = 0;

  rxq_entry_t wr_ent, rd_ent;
  logic       full, empty, push_fire, pop_fire;
  logic [CW-1:0] tally [NTAG];

  assign wr_ent.data = in_data;
  assign wr_ent.tags[TAG_PAR] = in_par_err;
  assign wr_ent.tags[TAG_FRM] = in_frm_err;

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push_fire = in_valid && in_ready && !fifo_clr;
  assign pop_fire  = out_valid && out_ready && !fifo_clr;

  rxq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .wr_en (push_fire),
    .wdata (wr_ent),
    .rd_en (pop_fire),
    .rdata (rd_ent),
    .full  (full),
    .empty (empty)
  );

  for (genvar g = 0; g < NTAG; g++) begin : g_tally
    rxq_tag_count #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fifo_clr),
      .inc   (push_fire && wr_ent.tags[g]),
      .dec   (pop_fire && rd_ent.tags[g]),
      .count (tally[g])
    );
  end

  assign out_data    = rd_ent.data;
  assign out_par_err = rd_ent.tags[TAG_PAR];
  assign out_frm_err = rd_ent.tags[TAG_FRM];
  assign counts_valid = err_summary;

  always_comb begin
    status_word = '0;
    status_word[PAR_LSB +: CW] = tally[TAG_PAR];
    status_word[FRM_LSB +: CW] = tally[TAG_FRM];
  end
endmodule

// File: rtl/rxq_err_tracker_chk.sv
module rxq_err_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_clr,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_par_err,
  input logic        in_frm_err,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_par_err,
  input logic [15:0] status_word
);
  logic push_ok, pop_ok;
  assign push_ok = in_valid && in_ready && !fifo_clr;
  assign pop_ok  = out_valid && out_ready && !fifo_clr;

  // R5: reserved bits stay zero
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15:14] == 2'b00 && status_word[7:6] == 2'b00);

  // R2: flagged push without pop raises parity tally by one
  a_r2_par_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && in_par_err && !pop_ok) |=>
      status_word[13:8] == 6'($past(status_word[13:8]) + 6'd1));

  // R2: flagged pop without push lowers parity tally by one
  a_r2_par_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && out_par_err && !push_ok) |=>
      status_word[13:8] == 6'($past(status_word[13:8]) - 6'd1));

  // R3: no transfer leaves framing tally alone
  a_r3_frm_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ok && !pop_ok && !fifo_clr) |=> $stable(status_word[5:0]));

  // R9: flush clears everything
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (status_word == 16'h0000) && !out_valid && in_ready);

  // R8: pop on empty with no push changes nothing
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !push_ok && !fifo_clr) |=> !out_valid && $stable(status_word));

  // R7: full with no pop stays full and unchanged
  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !pop_ok && !fifo_clr) |=> !in_ready && $stable(status_word));

  // R4: push and pop of same flags leave tallies unchanged
  a_r4_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && in_par_err == out_par_err) |=>
      $stable(status_word[13:8]));
endmodule

bind rxq_err_tracker rxq_err_tracker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_clr    (fifo_clr),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_par_err  (in_par_err),
  .in_frm_err  (in_frm_err),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_par_err (out_par_err),
  .status_word (status_word)
);

// File: tb/tb_rxq_err_tracker.sv
module tb_rxq_err_tracker;
  logic        clk = 1'b0;
  logic        rst_n, fifo_clr, in_valid, in_par_err, in_frm_err, out_ready, err_summary;
  logic [7:0]  in_data, out_data;
  logic        in_ready, out_valid, out_par_err, out_frm_err, counts_valid;
  logic [15:0] status_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  rxq_err_tracker dut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_par_err(in_par_err), .in_frm_err(in_frm_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_par_err(out_par_err), .out_frm_err(out_frm_err),
    .err_summary(err_summary), .counts_valid(counts_valid),
    .status_word(status_word)
  );

  // row: {push, par, frm, pop, exp_par[5:0], exp_frm[5:0]}
  localparam int NROW = 16;
  localparam logic [15:0] VEC [NROW] = '{
    {4'b1100, 6'd1, 6'd0},  // push P
    {4'b1010, 6'd1, 6'd1},  // push F
    {4'b1110, 6'd2, 6'd2},  // push PF
    {4'b1000, 6'd2, 6'd2},  // push clean
    {4'b0001, 6'd1, 6'd2},  // pop P
    {4'b1101, 6'd2, 6'd1},  // push P, pop F
    {4'b0000, 6'd2, 6'd1},  // idle
    {4'b0001, 6'd1, 6'd0},  // pop PF
    {4'b1011, 6'd1, 6'd1},  // push F, pop clean
    {4'b0001, 6'd0, 6'd1},  // pop P
    {4'b0001, 6'd0, 6'd0},  // pop F
    {4'b0001, 6'd0, 6'd0},  // pop on empty
    {4'b1111, 6'd1, 6'd1},  // push PF, pop on empty ignored
    {4'b1111, 6'd1, 6'd1},  // push PF, pop PF
    {4'b0001, 6'd0, 6'd0},  // pop PF
    {4'b1000, 6'd0, 6'd0}   // push clean
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int p, input int f);
    return {2'b00, 6'(p), 2'b00, 6'(f)};
  endfunction

  task automatic cycle(input bit push, input bit par, input bit frm, input bit pop,
                       input logic [7:0] d, input bit clr);
    in_valid = push; in_par_err = par; in_frm_err = frm; out_ready = pop;
    in_data = d; fifo_clr = clr;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_par_err = 0; in_frm_err = 0; out_ready = 0; fifo_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fifo_clr = 0; in_valid = 0; in_par_err = 0; in_frm_err = 0;
    out_ready = 0; in_data = 8'h00; err_summary = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1
    check(status_word == 16'h0000, "R1 status", status_word, 0);
    check(!out_valid && in_ready, "R1 flags", {out_valid, in_ready}, 2'b01);

    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NROW; i++) begin
      logic [15:0] v;
      v = VEC[i];
      cycle(v[15], v[14], v[13], v[12], 8'(i), 1'b0);
      check(status_word == word(int'(v[11:6]), int'(v[5:0])),
            $sformatf("R2 R3 R4 R5 R8 row %0d", i), status_word,
            word(int'(v[11:6]), int'(v[5:0])));
    end

    // R9: flush wins over a simultaneous push
    cycle(1, 1, 1, 0, 8'h55, 1);
    check(status_word == 16'h0000, "R9 status", status_word, 0);
    check(!out_valid, "R9 empty", out_valid, 0);

    // R8: pop on empty after flush
    cycle(0, 0, 0, 1, 8'h00, 0);
    check(!out_valid && status_word == 16'h0000, "R8 empty pop", status_word, 0);

    // R10: arrival order and carried flags
    cycle(1, 1, 0, 0, 8'hA1, 0);
    cycle(1, 0, 1, 0, 8'hB2, 0);
    cycle(1, 0, 0, 0, 8'hC3, 0);
    check(out_valid && out_data == 8'hA1 && out_par_err && !out_frm_err,
          "R10 head 0", {out_par_err, out_frm_err, out_data}, 10'h2A1);
    cycle(0, 0, 0, 1, 8'h00, 0);
    check(out_data == 8'hB2 && !out_par_err && out_frm_err,
          "R10 head 1", {out_par_err, out_frm_err, out_data}, 10'h1B2);
    cycle(0, 0, 0, 1, 8'h00, 0);
    check(out_data == 8'hC3 && !out_par_err && !out_frm_err,
          "R10 head 2", {out_par_err, out_frm_err, out_data}, 10'h0C3);
    cycle(0, 0, 0, 0, 8'h00, 1);

    // R6 R7: fill with 64 parity bytes, first 10 also framing
    for (int i = 0; i < 64; i++) cycle(1, 1, i < 10, 0, 8'(i), 0);
    check(status_word == word(0, 10), "R6 wrap", status_word, word(0, 10));
    check(!in_ready, "R7 full", in_ready, 0);
    cycle(1, 1, 1, 0, 8'hEE, 0);
    check(status_word == word(0, 10), "R7 dropped push", status_word, word(0, 10));
    cycle(0, 0, 0, 1, 8'h00, 0);
    check(status_word == word(63, 9) && in_ready, "R2 R7 pop from full",
          status_word, word(63, 9));
    check(out_data == 8'h01, "R7 contents kept", out_data, 8'h01);

    // R11
    err_summary = 1; #1;
    check(counts_valid, "R11 high", counts_valid, 1);
    err_summary = 0; #1;
    check(!counts_valid, "R11 low", counts_valid, 0);

    // R1: reset again from a non-empty state
    rst_n = 0;
    cycle(0, 0, 0, 0, 8'h00, 0);
    rst_n = 1;
    check(status_word == 16'h0000 && !out_valid && in_ready, "R1 re-reset",
          status_word, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule